// File: doc/BRIEF.md
# Byte-Parallel Configuration Receive Port

This block is the receive side of a byte-wide configuration port on a programmable device. A host drives bytes on an 8-bit bus. A byte is captured on a rising clock edge only while both active-low chip select and active-low write are asserted. After the program input goes high, the port first runs a memory-clear phase, and during that phase it holds the open-drain style init line low. Once the line is released, the port hunts the byte stream for a 32-bit synchronization pattern, which may arrive at any byte offset. It then packs the following bytes into aligned 32-bit words and presents each completed word with a one-cycle valid strobe.

When the host runs the clock above the handshake threshold, it signals this on a mode input. In that mode the port raises busy for one cycle after each captured byte, and the host holds its byte until busy is low. If the host changes direction (write to read or read to write) while chip select stays low, the packet in progress is aborted. The port then shows busy while the aborted operation drains, drops word alignment, and needs a new synchronization pattern. A CRC-16 covers every aligned word from the synchronization pattern up to and including an end marker. The word after the marker carries the expected checksum, and a match raises done while a mismatch pulls init low as an error flag.

Top module: `cfg_slave_port`

## Requirements
- R1: While `prog_hi` is low, `init_pull` is 1 and `busy` and `done` are 0. Once `prog_hi` is seen high, `init_pull` falls exactly CLR_CYC+1 (default 17) rising edges later, and bytes written before that are not captured.
- R2: A byte is captured only on an edge where `cs_n` and `wr_n` are both 0. Bytes on cycles with `cs_n`=1, or with `wr_n`=1 throughout a select window, are not captured.
- R3: After the pattern 32'hAA995566 has been captured at any byte offset, every four captured bytes form a word, with the first byte in bits [31:24]. `word_vld` is 1 and `word_out` holds that word in the cycle after the edge that captures the fourth byte.
- R4: No `word_vld` pulse occurs before the synchronization pattern has been found, and the pattern itself is not output as a word.
- R5: With `hs_mode`=0, `busy` stays 0 except during an abort drain, and a byte can be captured on every edge.
- R6: With `hs_mode`=1, `busy` is 1 in the cycle after each captured byte. A byte presented while `busy` is 1 is not captured.
- R7: A change of `wr_n` while `cs_n` stays 0 over two consecutive edges aborts the transfer. `busy` is then 1 for exactly DRAIN_CYC (default 4) cycles starting after that edge, and no byte is captured during those cycles.
- R8: After an abort, partly received bytes are discarded and no word is output until a new synchronization pattern has been captured.
- R9: The end marker is the word 32'hE000_0000. The checksum is CRC-16 with polynomial 0x8005, initial value 0, processed MSB first over every aligned word from after the pattern through the end marker. When the low 16 bits of the next word equal this value, `done` becomes 1 in the cycle after that word's last byte and `init_pull` stays 0.
- R10: On a checksum mismatch, `init_pull` becomes 1 and `done` stays 0, starting in the cycle after the checksum word's last byte.
- R11: After `done`, further written bytes produce no `word_vld`.
- R12: Pulling `prog_hi` low at any time brings `init_pull` to 1 and `done` to 0 one edge later, and the clear phase restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prog_hi | input | 1 | Program request; high starts memory clear and configuration |
| hs_mode | input | 1 | 1 when the clock is above the handshake threshold |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low (high means read direction) |
| din | input | 8 | Byte data bus |
| busy | output | 1 | Host must hold its byte while this is 1 |
| init_pull | output | 1 | 1 pulls the init line low (clear in progress or CRC error) |
| done | output | 1 | Bitstream complete with good checksum |
| word_vld | output | 1 | One-cycle strobe for an aligned word |
| word_out | output | 32 | Aligned word, first byte in the top bits |

## Verification
Word strobes, done and the error flag are registered, so each becomes visible one edge after the edge that captures the last byte of a word. Busy after a captured byte also appears one edge later, the abort drain covers the four cycles after the edge that samples the direction change, and init is released seventeen edges after program is seen high. The bench drives on falling edges and samples at the falling edge that directly follows the capturing rising edge, so each check lands in the exact cycle in which its result is due. In the handshake mode the byte driver waits on busy at falling edges, which keeps the byte count per word exact.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  localparam logic [31:0] SYNC_WORD = 32'hAA99_5566;
  localparam logic [31:0] END_WORD  = 32'hE000_0000;

  typedef enum logic [2:0] {
    ST_OFF, ST_CLR, ST_HUNT, ST_ALIGN, ST_SUM, ST_DRAIN, ST_DONE, ST_ERR
  } cfg_st_t;

  // One 32-bit word through a 16-bit CRC, most significant bit first.
  function automatic logic [15:0] crc16_word(input logic [15:0] c,
                                             input logic [31:0] d,
                                             input logic [15:0] poly);
    logic [15:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = (r << 1) ^ poly;
      else              r = r << 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic ff0_q, ff1_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ff0_q <= 1'b0;
      ff1_q <= 1'b0;
    end else begin
      ff0_q <= 1'b1;
      ff1_q <= ff0_q;
    end
  end

  assign srst_n = ff1_q;
endmodule

// File: rtl/cfg_word_asm.sv
module cfg_word_asm #(
  parameter int          BYTE_W = 8,
  parameter int          BYTES  = 4,
  parameter logic [31:0] SYNC   = cfg_pkg::SYNC_WORD
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic                    flush,
  input  logic                    align,
  input  logic [BYTE_W-1:0]       din,
  output logic                    sync_hit,
  output logic                    word_done,
  output logic [BYTE_W*BYTES-1:0] word_nxt
);
  localparam int WORD_W = BYTE_W * BYTES;
  localparam int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTES - 1);

  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [IDX_W-1:0]  idx_q, idx_d;

  assign word_nxt  = {shreg_q[WORD_W-BYTE_W-1:0], din};
  assign sync_hit  = take && !align && (word_nxt == SYNC[WORD_W-1:0]);
  assign word_done = take && align && (idx_q == LAST);

  always_comb begin
    shreg_d = shreg_q;
    idx_d   = idx_q;
    if (flush) begin
      shreg_d = '0;
      idx_d   = '0;
    end else if (take) begin
      shreg_d = word_nxt;
      if (sync_hit)   idx_d = '0;
      else if (align) idx_d = (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      idx_q   <= '0;
    end else begin
      shreg_q <= shreg_d;
      idx_q   <= idx_d;
    end
  end

  // A word needs BYTES captures, so two completions never sit back to back.
  assert_word_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done);

  // A sync hit starts a fresh word at byte slot zero.
  assert_realign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_hit && !flush) |=> (idx_q == '0));

endmodule

// File: rtl/cfg_crc16.sv
module cfg_crc16 #(
  parameter logic [15:0] POLY = 16'h8005
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        upd,
  input  logic [31:0] data,
  output logic [15:0] crc
);
  logic [15:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr)      crc_d = '0;
    else if (upd) crc_d = cfg_pkg::crc16_word(crc_q, data, POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;

  assert_crc_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == 16'h0000));

  assert_crc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !upd) |=> $stable(crc));

endmodule

// File: rtl/cfg_slave_port.sv
module cfg_slave_port #(
  parameter int          CLR_CYC   = 16,
  parameter int          DRAIN_CYC = 4,
  parameter logic [15:0] CRC_POLY  = 16'h8005
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prog_hi,
  input  logic        hs_mode,
  input  logic        cs_n,
  input  logic        wr_n,
  input  logic [7:0]  din,
  output logic        busy,
  output logic        init_pull,
  output logic        done,
  output logic        word_vld,
  output logic [31:0] word_out
);
  import cfg_pkg::*;

  localparam int MAXC  = (CLR_CYC > DRAIN_CYC) ? CLR_CYC : DRAIN_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic             rst_n_s;
  cfg_st_t          state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             cs_prev_q, wr_prev_q;
  logic             vld_q;
  logic [31:0]      word_q;

  logic        act_st, align, abort_ev, take;
  logic        sync_hit, word_done;
  logic [31:0] word_nxt;
  logic [15:0] crc_val;

  cfg_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_n_s));

  assign act_st   = (state_q == ST_HUNT) || (state_q == ST_ALIGN) || (state_q == ST_SUM);
  assign align    = (state_q == ST_ALIGN) || (state_q == ST_SUM);
  assign abort_ev = act_st && !cs_prev_q && !cs_n && (wr_n != wr_prev_q);
  assign take     = act_st && !cs_n && !wr_n && !busy_q && !abort_ev;

  cfg_word_asm #(.BYTE_W(8), .BYTES(4), .SYNC(SYNC_WORD)) u_asm (
    .clk(clk), .rst_n(rst_n_s), .take(take), .flush(abort_ev), .align(align),
    .din(din), .sync_hit(sync_hit), .word_done(word_done), .word_nxt(word_nxt)
  );

  cfg_crc16 #(.POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n_s), .clr(sync_hit),
    .upd(word_done && (state_q == ST_ALIGN)), .data(word_nxt), .crc(crc_val)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    busy_d  = take && hs_mode;
    if (!prog_hi) begin
      state_d = ST_OFF;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_OFF: begin
          state_d = ST_CLR;
          cnt_d   = CNT_W'(CLR_CYC - 1);
        end
        ST_CLR: begin
          if (cnt_q == '0) state_d = ST_HUNT;
          else             cnt_d   = cnt_q - 1'b1;
        end
        ST_HUNT, ST_ALIGN, ST_SUM: begin
          if (abort_ev) begin
            state_d = ST_DRAIN;
            cnt_d   = CNT_W'(DRAIN_CYC - 1);
          end else if (state_q == ST_HUNT) begin
            if (sync_hit) state_d = ST_ALIGN;
          end else if (state_q == ST_ALIGN) begin
            if (word_done && (word_nxt == END_WORD)) state_d = ST_SUM;
          end else if (word_done) begin
            state_d = (word_nxt[15:0] == crc_val) ? ST_DONE : ST_ERR;
          end
        end
        ST_DRAIN: begin
          if (cnt_q == '0) state_d = ST_HUNT;
          else             cnt_d   = cnt_q - 1'b1;
        end
        default: state_d = state_q;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q   <= ST_OFF;
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      cs_prev_q <= 1'b1;
      wr_prev_q <= 1'b1;
      vld_q     <= 1'b0;
      word_q    <= '0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      busy_q    <= busy_d;
      cs_prev_q <= cs_n;
      wr_prev_q <= wr_n;
      vld_q     <= word_done;
      if (word_done) word_q <= word_nxt;
    end
  end

  assign busy      = busy_q || (state_q == ST_DRAIN);
  assign init_pull = (state_q == ST_OFF) || (state_q == ST_CLR) || (state_q == ST_ERR);
  assign done      = (state_q == ST_DONE);
  assign word_vld  = vld_q;
  assign word_out  = word_q;

  assert_init_release_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(init_pull) |-> $past(state_q == ST_CLR));

  assert_slow_no_busy_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!hs_mode && !$past(hs_mode) && (state_q != ST_DRAIN)) |-> !busy);

  assert_fast_busy_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (take && hs_mode && prog_hi) |=> busy);

  assert_abort_drain_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (abort_ev && prog_hi) |=> (busy && (state_q == ST_DRAIN)));

  assert_word_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    word_vld |-> $past(align));

  assert_done_source_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(done) |-> $past(state_q == ST_SUM));

endmodule

// File: tb/tb_cfg_slave_port.sv
module tb_cfg_slave_port;
  localparam int CLR = 16;
  localparam int DRAIN = 4;
  localparam logic [31:0] SYNC = 32'hAA99_5566;
  localparam logic [31:0] ENDW = 32'hE000_0000;

  logic clk, rst_n, prog_hi, hs_mode, cs_n, wr_n;
  logic [7:0] din;
  logic busy, init_pull, done, word_vld;
  logic [31:0] word_out;

  int n_chk = 0, n_fail = 0, slow_busy = 0;
  bit watch_slow = 0, finished = 0;

  cfg_slave_port dut (
    .clk(clk), .rst_n(rst_n), .prog_hi(prog_hi), .hs_mode(hs_mode),
    .cs_n(cs_n), .wr_n(wr_n), .din(din), .busy(busy), .init_pull(init_pull),
    .done(done), .word_vld(word_vld), .word_out(word_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) if (watch_slow && busy) slow_busy++;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [31:0] w);
    logic [15:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) r = (r[15] ^ w[i]) ? ((r << 1) ^ 16'h8005) : (r << 1);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic put_byte(input logic [7:0] b, input bit chkb);
    while (busy) @(negedge clk);
    din = b; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    if (chkb && hs_mode) check(busy == 1'b1, "R6 busy after byte", busy, 1);
  endtask

  task automatic send_word(input logic [31:0] w, input bit exp_vld, input bit chkb);
    for (int i = 3; i >= 0; i--) put_byte(w[8*i +: 8], chkb);
    check(word_vld == exp_vld, exp_vld ? "R3 word strobe" : "R8/R4/R11 no word", word_vld, exp_vld);
    if (exp_vld) check(word_out == w, "R3 word value", word_out, w);
  endtask

  task automatic restart(input bit feed_sync);
    int k;
    idle(0);
    prog_hi = 1'b0;
    @(negedge clk);
    check(init_pull == 1'b1 && done == 1'b0, "R12 restart", {init_pull, done}, 2'b10);
    prog_hi = 1'b1;
    k = 0;
    while (k < 100) begin
      if (feed_sync && k < 4) begin
        din = SYNC[8*(3-k) +: 8]; cs_n = 1'b0; wr_n = 1'b0;
      end else begin
        cs_n = 1'b1; wr_n = 1'b1;
      end
      @(negedge clk);
      k++;
      if (!init_pull) break;
    end
    check(k == CLR + 1, "R1 clear length", k, CLR + 1);
    idle(1);
  endtask

  task automatic send_sync();
    for (int i = 3; i >= 0; i--) put_byte(SYNC[8*i +: 8], 0);
    check(word_vld == 1'b0, "R4 sync not output", word_vld, 0);
  endtask

  task automatic run_session(input bit fast, input int nwords, input bit bad);
    logic [15:0] crc;
    logic [31:0] w;
    hs_mode = fast;
    restart(0);
    watch_slow = !fast;
    slow_busy = 0;
    send_word($urandom & 32'h0F0F_0F0F, 0, 0);              // R4: junk before sync
    for (int i = 0; i < int'($urandom % 4); i++) put_byte(8'($urandom) & 8'h0F, 0);
    send_sync();
    crc = 16'h0;
    for (int i = 0; i < nwords; i++) begin
      w = $urandom;
      if (w == ENDW) w = w ^ 32'h1;
      send_word(w, 1, 1);
      crc = crc_step(crc, w);
    end
    send_word(ENDW, 1, 1);
    crc = crc_step(crc, ENDW);
    check(done == 1'b0, "R9 not done before checksum", done, 0);
    send_word({16'h0, bad ? ~crc : crc}, 1, 1);
    check(done == !bad, "R9/R10 done", done, !bad);
    check(init_pull == bad, "R9/R10 init flag", init_pull, bad);
    send_word(32'h1234_5678, 0, 0);                          // R11
    if (!fast) check(slow_busy == 0, "R5 no busy in slow mode", slow_busy, 0);
    watch_slow = 0;
    idle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog (all R) act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    int k;
    void'($urandom(32'd2024));
    rst_n = 1'b0; prog_hi = 1'b0; hs_mode = 1'b0;
    cs_n = 1'b1; wr_n = 1'b1; din = 8'h00;
    repeat (3) @(negedge clk);
    check(init_pull == 1'b1 && busy == 1'b0 && done == 1'b0 && word_vld == 1'b0,
          "R1 reset state", {init_pull, busy, done, word_vld}, 4'b1000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: sync bytes written during clear are ignored
    restart(1);
    send_word(32'h0102_0304, 0, 0);

    // Random sessions in both modes, some with a bad checksum
    for (int s = 0; s < 6; s++) run_session(s[0], 1 + int'($urandom % 5), (s == 2) || (s == 5));

    // R6: byte changed while busy is not taken
    hs_mode = 1'b1;
    restart(0);
    send_sync();
    w = $urandom;
    put_byte(w[31:24], 1);
    din = 8'h3C;
    @(negedge clk);
    for (int i = 2; i >= 0; i--) put_byte(w[8*i +: 8], 1);
    check(word_vld && word_out == w, "R6 held byte word", word_out, w);

    // R2: write outside select and read window are not captured
    hs_mode = 1'b0;
    restart(0);
    send_sync();
    w = $urandom;
    put_byte(w[31:24], 0);
    cs_n = 1'b1; wr_n = 1'b0; din = 8'h11; @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b1; din = 8'h22; @(negedge clk);
    cs_n = 1'b1; @(negedge clk);
    for (int i = 2; i >= 0; i--) put_byte(w[8*i +: 8], 0);
    check(word_vld && word_out == w, "R2 capture gating", word_out, w);

    // R7: write-to-read abort mid word, drain length
    put_byte(8'h5A, 0);
    put_byte(8'hA5, 0);
    wr_n = 1'b1;
    k = 0;
    for (int i = 1; i <= DRAIN + 1; i++) begin
      @(negedge clk);
      if (busy == (i <= DRAIN)) k++;
    end
    check(k == DRAIN + 1, "R7 drain busy window", k, DRAIN + 1);
    idle(1);
    // R8: alignment lost until new sync
    put_byte(8'h01, 0);
    put_byte(8'h02, 0);
    send_word(32'hCAFE_F00D, 0, 0);
    send_sync();
    send_word(32'h7654_3210, 1, 0);

    // R7: read-to-write abort
    idle(1);
    cs_n = 1'b0; wr_n = 1'b1; @(negedge clk);
    wr_n = 1'b0; @(negedge clk);
    check(busy == 1'b1, "R7 read-to-write abort busy", busy, 1);
    idle(DRAIN + 2);
    send_word(32'h0BAD_0BAD, 0, 0);
    send_sync();
    send_word(32'h1357_9BDF, 1, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule